// File: doc/BRIEF.md
# I2C Interrupt Status and Clear Unit

This unit gathers event pulses and level conditions from an I2C controller's master and slave state machines and from its transmit FIFO. It keeps them in one raw interrupt status word. Most bits are sticky and each one has its own clear-on-read strobe. A global clear-read strobe empties the bits that software services as a group.

The status bits follow mixed rules:

- The transmit-empty bit is a live level. It is derived from the FIFO fill level, the programmed threshold, the enable bit and the controller's activity.
- The transmit-abort bit holds a flush request towards the transmit FIFO for as long as it is set.
- The read-request bit holds a clock-stretch request (SCL held low) for as long as it is set.

A programmable mask, which comes out of reset as all ones, is applied to the status word. The masked bits are ORed into a single interrupt line.

All inputs are plain single-cycle strobes or levels. There is no data stream and no handshake at the block's edge.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset all status bits are 0, `irq`, `tx_flush` and `scl_hold` are 0, and the mask register is all ones. Status bits 2, 1 and 0 always read 0.
- R2: Status bit 10 is set one cycle after an `ev_start` pulse and bit 9 one cycle after an `ev_stop` pulse. Each stays set until its own clear strobe (`rd_clr_start` or `rd_clr_stop`) or `rd_clr_all` is applied, and drops in the following cycle.
- R3: Status bit 8 is set when `en` and `act` are both high in a cycle. It stays set after `act` falls. It is cleared by `rd_clr_act`, by `rd_clr_all`, or by any cycle with `en` low.
- R4: Status bit 7 is set by `ev_rxdone` and cleared by `rd_clr_rxdone` or `rd_clr_all`.
- R5: Status bit 6 is set by `ev_abort`, and `tx_flush` is high exactly while bit 6 is set. Only `rd_clr_abort` clears the bit; `rd_clr_all` does not clear it.
- R6: Status bit 5 is set by `ev_rdreq`, and `scl_hold` is high exactly while bit 5 is set. The bit is cleared one cycle after `rd_clr_rdreq`; `rd_clr_all` does not clear it.
- R7: Status bit 4 is combinational and not sticky. With `en` high it is 1 when `tx_level <= tx_thresh`. With `en` low it equals `act`.
- R8: Status bit 3 is set by `wr_cmd` while `tx_level` equals FIFO_DEPTH (32). It is cleared by `rd_clr_over`, by `rd_clr_all`, or by a cycle with both `en` and `act` low. A disabled controller that is still active keeps the bit.
- R9: `status_masked` is `status_raw & mask`, and `irq` is the OR of `status_masked`. A `mask_we` pulse loads `mask_wdata` into the mask in the next cycle.
- R10: If a set condition and a clear condition of a sticky bit occur in the same cycle, the bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Controller enable |
| act | input | 1 | Master or slave state machine active |
| ev_start | input | 1 | START or repeated START detected (pulse) |
| ev_stop | input | 1 | STOP detected (pulse) |
| ev_rxdone | input | 1 | Slave transmitter byte not acknowledged (pulse) |
| ev_abort | input | 1 | Transmit abort condition (pulse) |
| ev_rdreq | input | 1 | Addressed as slave for a read (pulse) |
| wr_cmd | input | 1 | Command written towards the TX FIFO (pulse) |
| tx_level | input | LVL_W | TX FIFO fill level |
| tx_thresh | input | LVL_W | TX empty threshold |
| rd_clr_all | input | 1 | Global clear-read strobe |
| rd_clr_start | input | 1 | Clear-read strobe for bit 10 |
| rd_clr_stop | input | 1 | Clear-read strobe for bit 9 |
| rd_clr_act | input | 1 | Clear-read strobe for bit 8 |
| rd_clr_rxdone | input | 1 | Clear-read strobe for bit 7 |
| rd_clr_abort | input | 1 | Clear-read strobe for bit 6 |
| rd_clr_rdreq | input | 1 | Clear-read strobe for bit 5 |
| rd_clr_over | input | 1 | Clear-read strobe for bit 3 |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | Mask write value |
| status_raw | output | 11 | Raw interrupt status word |
| status_masked | output | 11 | Status after masking |
| irq | output | 1 | Interrupt request |
| tx_flush | output | 1 | Flush request to the TX FIFO |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The hardest situations to reach are the ones where clear conditions overlap with sets or with each other. These include a clear-read landing in the same cycle as a new event, and the overflow bit surviving a disable while the state machines are still busy. Both are easy to miss with random strobes. The stimulus drives them directly:

- It fills the FIFO level to 32 and writes a command.
- It then drops `en` while holding `act`, and only later releases `act`.
- It fires events together with their own clear strobes, both when the bit is clear and when it is already set.

A vector table steps the transmit-empty level through its threshold and enable corners.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int STAT_W = 11;
  localparam int B_OVER   = 3;
  localparam int B_TXE    = 4;
  localparam int B_RDREQ  = 5;
  localparam int B_ABORT  = 6;
  localparam int B_RXDONE = 7;
  localparam int B_ACT    = 8;
  localparam int B_STOP   = 9;
  localparam int B_START  = 10;
  // sticky cell indices
  localparam int NSTICKY  = 7;
  localparam int S_OVER   = 0;
  localparam int S_RDREQ  = 1;
  localparam int S_ABORT  = 2;
  localparam int S_RXDONE = 3;
  localparam int S_ACT    = 4;
  localparam int S_STOP   = 5;
  localparam int S_START  = 6;
endpackage

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R10: set has priority over any clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
endmodule

// File: rtl/i2c_irq_txe.sv
module i2c_irq_txe #(
  parameter int LVL_W = 6
) (
  input  logic             en,
  input  logic             act,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  output logic             txe
);
  always_comb begin
    if (en) txe = (tx_level <= tx_thresh);
    else    txe = act;
  end
endmodule

// File: rtl/i2c_irq_mask.sv
module i2c_irq_mask #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] status,
  output logic [W-1:0] masked,
  output logic         irq
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign masked = status & mask_q;
  assign irq    = |masked;

  // R9: a write lands in the next cycle
  a_r9_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));
  a_r9_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              act,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rxdone,
  input  logic              ev_abort,
  input  logic              ev_rdreq,
  input  logic              wr_cmd,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  tx_thresh,
  input  logic              rd_clr_all,
  input  logic              rd_clr_start,
  input  logic              rd_clr_stop,
  input  logic              rd_clr_act,
  input  logic              rd_clr_rxdone,
  input  logic              rd_clr_abort,
  input  logic              rd_clr_rdreq,
  input  logic              rd_clr_over,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] status_raw,
  output logic [STAT_W-1:0] status_masked,
  output logic              irq,
  output logic              tx_flush,
  output logic              scl_hold
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [NSTICKY-1:0] s_set, s_clr, s_q;
  logic               fifo_full, txe;

  assign fifo_full = (tx_level == FULL_LVL);

  always_comb begin
    s_set[S_START]  = ev_start;
    s_clr[S_START]  = rd_clr_start | rd_clr_all;
    s_set[S_STOP]   = ev_stop;
    s_clr[S_STOP]   = rd_clr_stop | rd_clr_all;
    s_set[S_ACT]    = en & act;
    s_clr[S_ACT]    = rd_clr_act | rd_clr_all | ~en;
    s_set[S_RXDONE] = ev_rxdone;
    s_clr[S_RXDONE] = rd_clr_rxdone | rd_clr_all;
    s_set[S_ABORT]  = ev_abort;
    s_clr[S_ABORT]  = rd_clr_abort;
    s_set[S_RDREQ]  = ev_rdreq;
    s_clr[S_RDREQ]  = rd_clr_rdreq;
    s_set[S_OVER]   = wr_cmd & fifo_full;
    s_clr[S_OVER]   = rd_clr_over | rd_clr_all | (~en & ~act);
  end

  for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
    i2c_irq_sticky u_bit (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (s_set[i]),
      .clr  (s_clr[i]),
      .q    (s_q[i])
    );
  end

  i2c_irq_txe #(.LVL_W(LVL_W)) u_txe (
    .en       (en),
    .act      (act),
    .tx_level (tx_level),
    .tx_thresh(tx_thresh),
    .txe      (txe)
  );

  always_comb begin
    status_raw           = '0;
    status_raw[B_START]  = s_q[S_START];
    status_raw[B_STOP]   = s_q[S_STOP];
    status_raw[B_ACT]    = s_q[S_ACT];
    status_raw[B_RXDONE] = s_q[S_RXDONE];
    status_raw[B_ABORT]  = s_q[S_ABORT];
    status_raw[B_RDREQ]  = s_q[S_RDREQ];
    status_raw[B_TXE]    = txe;
    status_raw[B_OVER]   = s_q[S_OVER];
  end

  assign tx_flush = s_q[S_ABORT];
  assign scl_hold = s_q[S_RDREQ];

  i2c_irq_mask #(.W(STAT_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .status    (status_raw),
    .masked    (status_masked),
    .irq       (irq)
  );

  // R5: flush request survives everything but its own clear
  a_r5_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !rd_clr_abort) |=> tx_flush);
  a_r5_flush_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> tx_flush);
  // R6: hold released one cycle after its clear
  a_r6_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_rdreq && !ev_rdreq) |=> !scl_hold);
  a_r6_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rdreq |=> scl_hold);
  // R3: activity stays set while enabled and not read
  a_r3_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_raw[B_ACT] && en && !rd_clr_act && !rd_clr_all) |=> status_raw[B_ACT]);
  a_r3_act_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !status_raw[B_ACT]);
  // R8: overflow clears once disabled and idle
  a_r8_over_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !act && !(wr_cmd && fifo_full)) |=> !status_raw[B_OVER]);
  // R1: low bits never set
  a_r1_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_raw[2:0] == 3'b000);
endmodule

// File: tb/test_i2c_irq_status.sv
module test_i2c_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, act = 0;
  logic ev_start = 0, ev_stop = 0, ev_rxdone = 0, ev_abort = 0, ev_rdreq = 0, wr_cmd = 0;
  logic [5:0] tx_level = 6'd10, tx_thresh = 6'd0;
  logic rd_clr_all = 0, rd_clr_start = 0, rd_clr_stop = 0, rd_clr_act = 0;
  logic rd_clr_rxdone = 0, rd_clr_abort = 0, rd_clr_rdreq = 0, rd_clr_over = 0;
  logic mask_we = 0;
  logic [10:0] mask_wdata = '0;
  logic [10:0] status_raw, status_masked;
  logic irq, tx_flush, scl_hold;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_irq_status i_i2c_irq_status (
    .clk(clk), .rst_n(rst_n), .en(en), .act(act),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rxdone(ev_rxdone),
    .ev_abort(ev_abort), .ev_rdreq(ev_rdreq), .wr_cmd(wr_cmd),
    .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rd_clr_all(rd_clr_all), .rd_clr_start(rd_clr_start), .rd_clr_stop(rd_clr_stop),
    .rd_clr_act(rd_clr_act), .rd_clr_rxdone(rd_clr_rxdone), .rd_clr_abort(rd_clr_abort),
    .rd_clr_rdreq(rd_clr_rdreq), .rd_clr_over(rd_clr_over),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .status_raw(status_raw), .status_masked(status_masked),
    .irq(irq), .tx_flush(tx_flush), .scl_hold(scl_hold)
  );

  // {en, act, level[5:0], thresh[5:0], expected txe}
  localparam logic [14:0] VEC [8] = '{
    {1'b1, 1'b0, 6'd0,  6'd0,  1'b1},
    {1'b1, 1'b0, 6'd5,  6'd4,  1'b0},
    {1'b1, 1'b1, 6'd4,  6'd4,  1'b1},
    {1'b1, 1'b0, 6'd3,  6'd4,  1'b1},
    {1'b1, 1'b1, 6'd32, 6'd31, 1'b0},
    {1'b0, 1'b1, 6'd9,  6'd2,  1'b1},
    {1'b0, 1'b0, 6'd0,  6'd5,  1'b0},
    {1'b1, 1'b0, 6'd32, 6'd32, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic quiet();
    ev_start = 0; ev_stop = 0; ev_rxdone = 0; ev_abort = 0; ev_rdreq = 0; wr_cmd = 0;
    rd_clr_all = 0; rd_clr_start = 0; rd_clr_stop = 0; rd_clr_act = 0;
    rd_clr_rxdone = 0; rd_clr_abort = 0; rd_clr_rdreq = 0; rd_clr_over = 0;
    mask_we = 0;
  endtask

  // one clock edge, then pulses released, sampled at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    quiet();
    #1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state (en=0, act=0 so txe=0)
    chk("R1 status", status_raw, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flush", tx_flush, 0);
    chk("R1 hold", scl_hold, 0);

    // R2 start / stop; R9 reset mask lets irq through
    ev_start = 1; tick();
    chk("R2 start set", status_raw[10], 1);
    chk("R9 reset mask all ones irq", irq, 1);
    tick();
    chk("R2 start held", status_raw[10], 1);
    rd_clr_start = 1; tick();
    chk("R2 start cleared", status_raw[10], 0);
    ev_stop = 1; tick();
    chk("R2 stop set", status_raw[9], 1);
    rd_clr_all = 1; tick();
    chk("R2 stop global clear", status_raw[9], 0);
    chk("R1 low bits zero", status_raw[2:0], 0);

    // R3 activity
    tx_level = 6'd10; tx_thresh = 6'd0;
    en = 1; act = 1; tick();
    act = 0; tick();
    chk("R3 act sticky after idle", status_raw[8], 1);
    rd_clr_act = 1; tick();
    chk("R3 act read clear", status_raw[8], 0);
    act = 1; tick(); act = 0;
    rd_clr_all = 1; tick();
    chk("R3 act global clear", status_raw[8], 0);
    act = 1; tick(); act = 0; tick();
    chk("R3 act reset again", status_raw[8], 1);
    en = 0; tick();
    chk("R3 act disable clear", status_raw[8], 0);

    // R4 rxdone
    ev_rxdone = 1; tick();
    chk("R4 rxdone set", status_raw[7], 1);
    rd_clr_rxdone = 1; tick();
    chk("R4 rxdone cleared", status_raw[7], 0);

    // R5 abort and flush
    ev_abort = 1; tick();
    chk("R5 abort set", status_raw[6], 1);
    chk("R5 flush high", tx_flush, 1);
    rd_clr_all = 1; tick();
    chk("R5 global does not clear", tx_flush, 1);
    rd_clr_abort = 1; tick();
    chk("R5 abort cleared", status_raw[6], 0);
    chk("R5 flush low", tx_flush, 0);

    // R6 read request and hold
    ev_rdreq = 1; tick();
    chk("R6 hold high", scl_hold, 1);
    rd_clr_all = 1; tick();
    chk("R6 global does not clear", status_raw[5], 1);
    rd_clr_rdreq = 1; tick();
    chk("R6 hold released", scl_hold, 0);

    // R7 transmit-empty vector table
    for (int i = 0; i < 8; i++) begin
      en = VEC[i][14]; act = VEC[i][13];
      tx_level = VEC[i][12:7]; tx_thresh = VEC[i][6:1];
      #1;
      chk($sformatf("R7 txe vector %0d", i), status_raw[4], VEC[i][0]);
    end
    en = 0; act = 0; tx_level = 6'd10; tx_thresh = 6'd0; tick();

    // R8 overflow
    en = 1; tx_level = 6'd31; wr_cmd = 1; tick();
    chk("R8 no set below full", status_raw[3], 0);
    tx_level = 6'd32; wr_cmd = 1; tick();
    chk("R8 over set", status_raw[3], 1);
    en = 0; act = 1; tick();
    chk("R8 held while active", status_raw[3], 1);
    act = 0; tick();
    chk("R8 cleared when idle", status_raw[3], 0);
    en = 1; wr_cmd = 1; tick();
    rd_clr_over = 1; tick();
    chk("R8 read clear", status_raw[3], 0);
    tx_level = 6'd10;

    // R10 set wins
    ev_start = 1; rd_clr_start = 1; tick();
    chk("R10 set wins from clear", status_raw[10], 1);
    ev_start = 1; rd_clr_all = 1; tick();
    chk("R10 set wins while set", status_raw[10], 1);
    ev_rdreq = 1; rd_clr_rdreq = 1; tick();
    chk("R10 rdreq set wins", scl_hold, 1);
    rd_clr_rdreq = 1; rd_clr_start = 1; tick();
    en = 0; tick();

    // R9 mask
    mask_we = 1; mask_wdata = 11'h3FF; tick();
    ev_start = 1; tick();
    chk("R9 masked raw visible", status_raw[10], 1);
    chk("R9 masked irq low", irq, 0);
    chk("R9 masked word", status_masked, 0);
    mask_we = 1; mask_wdata = 11'h7FF; tick();
    chk("R9 unmasked irq", irq, 1);
    chk("R9 unmasked word", status_masked, 11'h400);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule